// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that software drives through a small synchronous register port. Three tick-enable inputs stand in for independent time bases. A mode register selects one of them and sets a prescaler that divides the chosen tick by a power of four. The prescaled tick advances a 16-bit up-counter. When that counter matches a programmed limit, the block raises a reset request for one clock and the counter starts again from zero.

Software sets the watchdog up in a fixed order. It stops the counter, writes the divide code with no source selected, writes the limit, clears the counter, writes the divide code again with the source bit set, and then starts counting. Each write of zero to the counter register restarts the count. This write is the keep-alive, and software must repeat it before the limit comes round.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `rst_req` is low.
- R2: Registers sit at word offsets, with `reg_addr[1:0]` equal to 0: limit at 0x0 (16 bits), run at 0x4 (bit 0), counter at 0x8 (16 bits) and mode at 0xC (bits [5:0], upper bits read as zero). Reads are combinational.
- R3: While run is set, the counter increases by exactly one on each prescaled tick and holds between ticks.
- R4: Mode bits 0, 1 and 2 select `tick_in[0]`, `tick_in[1]` and `tick_in[2]`. If no bit or more than one bit is set, no prescaled tick occurs. Ticks on unselected inputs have no effect.
- R5: Mode bits [5:3] hold a divide code c. The selected tick is divided by 4^c for c from 0 to 5, and codes 6 and 7 divide by 1024.
- R6: When a prescaled tick finds the counter equal to the limit, `rst_req` is high for the next clock and the counter reads zero. With a constant source tick, limit D and divide N, `rst_req` rises N*(D+1) clocks after the run-enable write.
- R7: A write to the counter loads the written value, so writing zero is the keep-alive. A counter write in the same cycle as an expiring tick takes priority, and no reset request results.
- R8: While run is clear, the counter holds its value and the prescaler is held at zero.
- R9: A mode write clears the prescaler, so the first prescaled tick comes a full divide period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tick_in | input | 3 | Tick enables of the three time bases |
| rst_req | output | 1 | One-clock reset request on expiry |

## Verification
The keep-alive write and the expiry can land on the same clock edge. The bench sets up a limit of 3 with divide-by-1 and waits three clocks. It then issues the counter write so that the write edge is the one on which the expiring tick would fire. `rst_req` must stay low after that edge, and the next expiry must arrive exactly four clocks later. This shows that the write won and the count restarted from zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int ADDR_W = 4;
   typedef enum logic [1:0] {
      SEL_LIMIT = 2'd0,
      SEL_RUN   = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_MODE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int CNT_W  = 16,
   parameter int NSRC   = 3,
   parameter int CODE_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [wdog_pkg::ADDR_W-1:0]   addr,
   input  logic [CNT_W-1:0]              wdata,
   input  logic [CNT_W-1:0]              count,
   output logic [CNT_W-1:0]              limit_q,
   output logic                          run_q,
   output logic [NSRC+CODE_W-1:0]        mode_q,
   output logic                          wr_count,
   output logic                          wr_mode,
   output logic [CNT_W-1:0]              rdata
);
   import wdog_pkg::*;
   localparam int MODE_W = NSRC + CODE_W;

   logic     aligned;
   reg_sel_e sel;

   assign aligned  = (addr[1:0] == 2'b00);
   assign sel      = reg_sel_e'(addr[3:2]);
   assign wr_count = we && aligned && (sel == SEL_COUNT);
   assign wr_mode  = we && aligned && (sel == SEL_MODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= '0;
         run_q   <= 1'b0;
         mode_q  <= '0;
      end else if (we && aligned) begin
         case (sel)
            SEL_LIMIT: limit_q <= wdata;
            SEL_RUN:   run_q   <= wdata[0];
            SEL_MODE:  mode_q  <= wdata[MODE_W-1:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (aligned) begin
         case (sel)
            SEL_LIMIT: rdata = limit_q;
            SEL_RUN:   rdata = {{(CNT_W-1){1'b0}}, run_q};
            SEL_COUNT: rdata = count;
            SEL_MODE:  rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int NSRC     = 3,
   parameter int CODE_W   = 3,
   parameter int MAX_CODE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic [NSRC-1:0]   src_sel,
   input  logic [CODE_W-1:0] code,
   input  logic [NSRC-1:0]   ticks,
   output logic              ptick
);
   localparam int DIV_W = 2 * MAX_CODE;

   logic [NSRC-1:0]  hit;
   logic             src_tick;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] lim;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = src_sel[i] & ticks[i];
   end

   assign src_tick = $onehot(src_sel) && (|hit);

   function automatic logic [DIV_W-1:0] lim_of(input logic [CODE_W-1:0] c);
      int e;
      e = (int'(c) > MAX_CODE) ? MAX_CODE : int'(c);
      return DIV_W'((32'd1 << (2 * e)) - 32'd1);
   endfunction

   assign lim   = lim_of(code);
   assign ptick = run && !clr && src_tick && (div_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || clr) begin
         div_q <= '0;
      end else if (src_tick) begin
         div_q <= (div_q == lim) ? '0 : div_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (load) begin
            count <= load_val;
         end else if (tick) begin
            if (count == limit) begin
               count  <= '0;
               expire <= 1'b1;
            end else begin
               count <= count + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
   parameter int CNT_W    = 16,
   parameter int NSRC     = 3,
   parameter int CODE_W   = 3,
   parameter int MAX_CODE = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [wdog_pkg::ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]            reg_wdata,
   output logic [CNT_W-1:0]            reg_rdata,
   input  logic [NSRC-1:0]             tick_in,
   output logic                        rst_req
);
   localparam int MODE_W = NSRC + CODE_W;

   if (CNT_W < MODE_W) begin : g_bad_cnt
      $error("CNT_W must hold the mode field");
   end
   if (MAX_CODE < 1 || MAX_CODE > (1 << CODE_W) - 1 || MAX_CODE > 14) begin : g_bad_code
      $error("MAX_CODE out of range for CODE_W");
   end
   if (NSRC < 1) begin : g_bad_src
      $error("NSRC must be at least 1");
   end

   logic [CNT_W-1:0]  limit_q;
   logic              run_q;
   logic [MODE_W-1:0] mode_q;
   logic              wr_count;
   logic              wr_mode;
   logic [CNT_W-1:0]  count_q;
   logic              ptick;

   wdog_regs #(.CNT_W(CNT_W), .NSRC(NSRC), .CODE_W(CODE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .count    (count_q),
      .limit_q  (limit_q),
      .run_q    (run_q),
      .mode_q   (mode_q),
      .wr_count (wr_count),
      .wr_mode  (wr_mode),
      .rdata    (reg_rdata)
   );

   wdog_prescale #(.NSRC(NSRC), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .clr     (wr_mode),
      .src_sel (mode_q[NSRC-1:0]),
      .code    (mode_q[MODE_W-1:NSRC]),
      .ticks   (tick_in),
      .ptick   (ptick)
   );

   wdog_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_count),
      .load_val (reg_wdata),
      .tick     (ptick),
      .limit    (limit_q),
      .count    (count_q),
      .expire   (rst_req)
   );
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
   parameter int CNT_W = 16,
   parameter int NSRC  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             load,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] limit,
   input logic             ptick,
   input logic [NSRC-1:0]  src,
   input logic             rst_req
);
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (count == '0));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ptick && !load && count != limit) |=> (count == $past(count) + CNT_W'(1)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !ptick);

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((count == $past(wdata)) && !rst_req));

   assert_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(src) != 1) |-> !ptick);
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W), .NSRC(NSRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run_q),
   .load    (wr_count),
   .wdata   (reg_wdata),
   .count   (count_q),
   .limit   (limit_q),
   .ptick   (ptick),
   .src     (mode_q[NSRC-1:0]),
   .rst_req (rst_req)
);

// File: tb/wdog_prescaled_tb_top.sv
module wdog_prescaled_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_LIM = 4'h0, A_RUN = 4'h4, A_CNT = 4'h8, A_MODE = 4'hC;
   localparam int NV = 10;
   // {src[2:0], code[2:0], limit[15:0], expected clocks to rst_req (0 = never)}
   localparam logic [53:0] VEC [NV] = '{
      {3'b001, 3'd0, 16'd5, 32'd6},
      {3'b010, 3'd1, 16'd2, 32'd12},
      {3'b100, 3'd2, 16'd1, 32'd32},
      {3'b001, 3'd3, 16'd0, 32'd64},
      {3'b010, 3'd4, 16'd1, 32'd512},
      {3'b100, 3'd5, 16'd1, 32'd2048},
      {3'b001, 3'd7, 16'd0, 32'd1024},
      {3'b010, 3'd6, 16'd0, 32'd1024},
      {3'b011, 3'd0, 16'd2, 32'd0},
      {3'b000, 3'd0, 16'd2, 32'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  tick_in = '0;
   logic        rst_req;
   int          n_chk = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wdog_prescaled dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tick_in   (tick_in),
      .rst_req   (rst_req)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called at a falling edge; the next rising edge performs the write
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic setup(input logic [2:0] src, input logic [2:0] code, input logic [15:0] lim);
      wr(A_RUN, 16'd0);
      wr(A_MODE, {10'd0, code, 3'b000});
      wr(A_LIM, lim);
      wr(A_CNT, 16'd0);
      wr(A_MODE, {10'd0, code, src});
      wr(A_RUN, 16'd1);
   endtask

   task automatic wait_req(input int max, output int cyc);
      int n = 0;
      bit seen = 0;
      while (!seen && n < max) begin
         @(negedge clk);
         n++;
         if (rst_req) seen = 1;
      end
      cyc = seen ? n : 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] rv;
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 rst_req", rst_req, 0);
      rd(A_LIM, rv);  chk("R1 limit", rv, 0);
      rd(A_RUN, rv);  chk("R1 run", rv, 0);
      rd(A_CNT, rv);  chk("R1 count", rv, 0);
      rd(A_MODE, rv); chk("R1 mode", rv, 0);

      // R2: register map readback
      wr(A_LIM, 16'hABCD);  rd(A_LIM, rv);  chk("R2 limit", rv, 16'hABCD);
      wr(A_MODE, 16'hFFFF); rd(A_MODE, rv); chk("R2 mode width", rv, 16'h003F);
      wr(A_MODE, 16'h002D); rd(A_MODE, rv); chk("R2 mode", rv, 16'h002D);
      wr(A_MODE, 16'h0000);

      // vector table: R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         logic [53:0] v;
         int exp;
         v = VEC[i];
         exp = int'(v[31:0]);
         tick_in = ($countones(v[53:51]) == 1) ? v[53:51] : 3'b111;
         setup(v[53:51], v[50:48], v[47:32]);
         wait_req((exp == 0) ? 300 : exp + 50, cyc);
         chk($sformatf("R5 R6 R4 vec%0d period", i), cyc, exp);
         rd(A_CNT, rv);
         chk($sformatf("R6 R4 vec%0d count", i), rv, 0);
         if (exp > 1) begin
            @(negedge clk);
            chk($sformatf("R6 vec%0d pulse width", i), rst_req, 0);
         end
      end

      // R3: count advances once per tick
      tick_in = 3'b001;
      setup(3'b001, 3'd0, 16'd100);
      repeat (7) @(negedge clk);
      rd(A_CNT, rv); chk("R3 count", rv, 7);

      // R8: stopped counter holds
      wr(A_RUN, 16'd0);
      repeat (5) @(negedge clk);
      rd(A_CNT, rv); chk("R8 hold", rv, 8);
      chk("R8 no req", rst_req, 0);

      // R7: keep-alive restarts the count
      setup(3'b001, 3'd0, 16'd10);
      repeat (8) @(negedge clk);
      wr(A_CNT, 16'd0);
      wait_req(60, cyc); chk("R7 ping", cyc, 11);

      // R7: keep-alive on the expiring edge
      setup(3'b001, 3'd0, 16'd3);
      repeat (3) @(negedge clk);
      wr(A_CNT, 16'd0);
      chk("R7 collision no req", rst_req, 0);
      wait_req(60, cyc); chk("R7 collision restart", cyc, 4);

      // R7: counter load value
      wr(A_RUN, 16'd0);
      wr(A_CNT, 16'h1234);
      rd(A_CNT, rv); chk("R7 load", rv, 16'h1234);

      // R9: mode write clears prescaler
      setup(3'b001, 3'd1, 16'd0);
      repeat (2) @(negedge clk);
      wr(A_MODE, {10'd0, 3'd1, 3'b001});
      wait_req(60, cyc); chk("R9 divider clear", cyc, 4);

      // R4: unselected ticks ignored
      tick_in = 3'b101;
      setup(3'b010, 3'd0, 16'd2);
      wait_req(50, cyc); chk("R4 other ticks", cyc, 0);
      rd(A_CNT, rv); chk("R4 count idle", rv, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule